// File: doc/BRIEF.md
# Segment-Tagged Guarded Memory

This block is a 256-word memory in which every 16-bit word is stored together with a 3-bit segment tag. The tag says what kind of content the word holds. Every write is judged against the tag already stored at the target word. A word whose tag is free can be claimed by any legal write. A claimed word can only be rewritten with the same class. The memory has two write ports and one read port. The loader port is privileged and may place any real content class. The execution port may only place dynamically generated data.

Each write port returns a one-cycle result on the cycle after its request: either an accept pulse or a reject pulse. A rejected write changes nothing in the memory. The read port returns the stored data and the stored tag together, one cycle after the address is presented. Software above this block can therefore check that a word is being used as the class it was written as.

Top module: `seg_guard_mem`

## Requirements
- R1: After reset, every word reads back tag 0 and data 0, and all four write result outputs are low.
- R2: `rd_data` and `rd_seg` show the word at the `rd_addr` sampled on the previous clock edge. A write taken at that same edge is not yet visible.
- R3: Tags are 3 bits wide with these encodings: 0 free, 1 interrupt data, 2 interrupt handler table, 3 interrupt handler code, 4 program data, 5 program code, 6 dynamic data, 7 invalid.
- R4: A write with a legal tag is accepted only when the stored tag is 0 or equals the incoming tag.
- R5: The loader port may write tags 1 to 6. A write tag of 0 or 7 is rejected on either port.
- R6: The execution port accepts only tag 6. Tags 1 to 5 are privileged and are always rejected there.
- R7: A rejected write leaves both the data and the tag of the target word unchanged.
- R8: For each request, exactly one of ack or nak for that port pulses high for one cycle, on the cycle after the request. Both are low when the port is idle.
- R9: When both write ports target the same address in one cycle, the loader request is judged by its own rules and the execution request is rejected.
- R10: An accepted write stores its data and tag. A read presented on the following cycle returns them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Loader write request |
| ld_addr | input | 8 | Loader write address |
| ld_data | input | 16 | Loader write data |
| ld_seg | input | 3 | Loader write tag |
| ld_ack | output | 1 | Loader write accepted (one cycle after request) |
| ld_nak | output | 1 | Loader write rejected (one cycle after request) |
| ex_en | input | 1 | Execution write request |
| ex_addr | input | 8 | Execution write address |
| ex_data | input | 16 | Execution write data |
| ex_seg | input | 3 | Execution write tag |
| ex_ack | output | 1 | Execution write accepted |
| ex_nak | output | 1 | Execution write rejected |
| rd_addr | input | 8 | Read address, sampled every cycle |
| rd_data | output | 16 | Stored data of the sampled word |
| rd_seg | output | 3 | Stored tag of the sampled word |

## Verification
The assertions assume that the inputs are stable and known at each rising edge. They also assume that an address or tag carries meaning only while its enable is high. The stimulus changes every input only on the falling edge. Random addresses are drawn from a small window so that claims, same-class rewrites, foreign-class rejections and same-address collisions between the ports occur often. Random tags cover all eight codes, including 0 and 7, so both rejection paths get steady use.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
    localparam int SEG_W  = 3;
    localparam int DATA_W = 16;

    localparam logic [SEG_W-1:0] SEG_FREE      = 3'd0;
    localparam logic [SEG_W-1:0] SEG_IRQ_DATA  = 3'd1;
    localparam logic [SEG_W-1:0] SEG_IRQ_TABLE = 3'd2;
    localparam logic [SEG_W-1:0] SEG_IRQ_CODE  = 3'd3;
    localparam logic [SEG_W-1:0] SEG_PROG_DATA = 3'd4;
    localparam logic [SEG_W-1:0] SEG_PROG_CODE = 3'd5;
    localparam logic [SEG_W-1:0] SEG_DYN       = 3'd6;
    localparam logic [SEG_W-1:0] SEG_BAD       = 3'd7;

    typedef struct packed {
        logic [SEG_W-1:0]  seg;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        logic ld_ack;
        logic ld_nak;
        logic ex_ack;
        logic ex_nak;
    } result_t;
endpackage

// File: rtl/seg_guard_rule.sv
module seg_guard_rule
    import seg_guard_pkg::*;
#(
    parameter bit PRIV = 1'b0
) (
    input  logic             req,
    input  logic             blocked,
    input  logic [SEG_W-1:0] cur_seg,
    input  logic [SEG_W-1:0] new_seg,
    output logic             ok
);
    logic tag_legal;
    logic owner_match;

    generate
        if (PRIV) begin : g_priv
            // R5: loader places any real content class
            assign tag_legal = (new_seg != SEG_FREE) && (new_seg != SEG_BAD);
        end else begin : g_user
            // R6: execution side places dynamic data only
            assign tag_legal = (new_seg == SEG_DYN);
        end
    endgenerate

    // R4: free slot or same class
    assign owner_match = (cur_seg == SEG_FREE) || (cur_seg == new_seg);
    assign ok = req && !blocked && tag_legal && owner_match;
endmodule

// File: rtl/seg_guard_store.sv
module seg_guard_store
    import seg_guard_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  slot_t             ld_slot,
    input  logic              ex_we,
    input  logic [ADDR_W-1:0] ex_addr,
    input  slot_t             ex_slot,
    input  logic [ADDR_W-1:0] rd_addr,
    output slot_t             ld_cur,
    output slot_t             ex_cur,
    output slot_t             rd_slot
);
    localparam int DEPTH = 1 << ADDR_W;

    slot_t mem_q [DEPTH];
    slot_t mem_d [DEPTH];
    slot_t rd_q, rd_d;

    assign ld_cur  = mem_q[ld_addr];
    assign ex_cur  = mem_q[ex_addr];
    assign rd_slot = rd_q;

    always_comb begin
        mem_d = mem_q;
        rd_d  = mem_q[rd_addr];
        if (ld_we) mem_d[ld_addr] = ld_slot;
        if (ex_we) mem_d[ex_addr] = ex_slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rd_q <= '0;
        end else begin
            mem_q <= mem_d;
            rd_q  <= rd_d;
        end
    end

    // R10: an accepted loader write lands in the addressed slot
    p_ld_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |=> mem_q[$past(ld_addr)] == $past(ld_slot));
    // R10: an accepted execution write lands with the dynamic tag
    p_ex_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ex_we |=> (mem_q[$past(ex_addr)].seg == SEG_DYN)
               && (mem_q[$past(ex_addr)].data == $past(ex_slot.data)));
    // R9: the two write enables never hit one slot together
    p_no_dual_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_we && ex_we && (ld_addr == ex_addr)));
endmodule

// File: rtl/seg_guard_mem.sv
module seg_guard_mem
    import seg_guard_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [SEG_W-1:0]  ld_seg,
    output logic              ld_ack,
    output logic              ld_nak,
    input  logic              ex_en,
    input  logic [ADDR_W-1:0] ex_addr,
    input  logic [DATA_W-1:0] ex_data,
    input  logic [SEG_W-1:0]  ex_seg,
    output logic              ex_ack,
    output logic              ex_nak,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEG_W-1:0]  rd_seg
);
    slot_t   ld_cur, ex_cur, rd_slot;
    logic    ld_ok, ex_ok, clash;
    result_t res_q, res_d;

    assign clash = ld_en && ex_en && (ld_addr == ex_addr);

    seg_guard_rule #(.PRIV(1'b1)) i_ld_rule (
        .req(ld_en), .blocked(1'b0), .cur_seg(ld_cur.seg),
        .new_seg(ld_seg), .ok(ld_ok)
    );

    seg_guard_rule #(.PRIV(1'b0)) i_ex_rule (
        .req(ex_en), .blocked(clash), .cur_seg(ex_cur.seg),
        .new_seg(ex_seg), .ok(ex_ok)
    );

    seg_guard_store #(.ADDR_W(ADDR_W)) i_store (
        .clk(clk), .rst_n(rst_n),
        .ld_we(ld_ok), .ld_addr(ld_addr), .ld_slot('{seg: ld_seg, data: ld_data}),
        .ex_we(ex_ok), .ex_addr(ex_addr), .ex_slot('{seg: ex_seg, data: ex_data}),
        .rd_addr(rd_addr),
        .ld_cur(ld_cur), .ex_cur(ex_cur), .rd_slot(rd_slot)
    );

    always_comb begin
        res_d        = '0;
        res_d.ld_ack = ld_ok;
        res_d.ld_nak = ld_en && !ld_ok;
        res_d.ex_ack = ex_ok;
        res_d.ex_nak = ex_en && !ex_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign ld_ack  = res_q.ld_ack;
    assign ld_nak  = res_q.ld_nak;
    assign ex_ack  = res_q.ex_ack;
    assign ex_nak  = res_q.ex_nak;
    assign rd_data = rd_slot.data;
    assign rd_seg  = rd_slot.seg;

    // R8: a loader request yields exactly one result pulse next cycle
    p_ld_one_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (ld_ack ^ ld_nak));
    // R8: an idle loader port produces no result
    p_ld_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> !ld_ack && !ld_nak);
    // R8: an execution request yields exactly one result pulse next cycle
    p_ex_one_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ex_en |=> (ex_ack ^ ex_nak));
    // R5: free and invalid tags are refused on the loader port
    p_ld_bad_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en && (ld_seg == SEG_FREE || ld_seg == SEG_BAD) |=> ld_nak);
    // R6: execution port refuses anything but dynamic data
    p_ex_dyn_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ex_en && (ex_seg != SEG_DYN) |=> ex_nak);
    // R9: same-address collision rejects the execution write
    p_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en && ex_en && (ld_addr == ex_addr) |=> ex_nak && !ex_ack);
endmodule

// File: tb/test_seg_guard_mem.sv
module test_seg_guard_mem;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0, ex_en = 1'b0;
    logic [7:0]  ld_addr = '0, ex_addr = '0, rd_addr = '0;
    logic [15:0] ld_data = '0, ex_data = '0;
    logic [2:0]  ld_seg = '0, ex_seg = '0;
    logic        ld_ack, ld_nak, ex_ack, ex_nak;
    logic [15:0] rd_data;
    logic [2:0]  rd_seg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [15:0] m_data [256];
    logic [2:0]  m_seg  [256];
    logic        e_ld_ok, e_ex_ok;
    logic [15:0] e_rd_data;
    logic [2:0]  e_rd_seg;

    always #10 clk = ~clk;

    seg_guard_mem i_seg_guard_mem (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data), .ld_seg(ld_seg),
        .ld_ack(ld_ack), .ld_nak(ld_nak),
        .ex_en(ex_en), .ex_addr(ex_addr), .ex_data(ex_data), .ex_seg(ex_seg),
        .ex_ack(ex_ack), .ex_nak(ex_nak),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_seg(rd_seg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic ld_rule(input logic [2:0] cur, input logic [2:0] s);
        return (s >= 3'd1) && (s <= 3'd6) && (cur == 3'd0 || cur == s);
    endfunction

    function automatic logic ex_rule(input logic [2:0] cur, input logic [2:0] s);
        return (s == 3'd6) && (cur == 3'd0 || cur == 3'd6);
    endfunction

    // One clock: drive at falling edge, update the model, sample after the rising edge
    task automatic step(input logic le, input logic [7:0] la, input logic [15:0] ld,
                        input logic [2:0] ls, input logic ee, input logic [7:0] ea,
                        input logic [15:0] ed, input logic [2:0] es, input logic [7:0] ra);
        @(negedge clk);
        ld_en = le; ld_addr = la; ld_data = ld; ld_seg = ls;
        ex_en = ee; ex_addr = ea; ex_data = ed; ex_seg = es;
        rd_addr = ra;
        e_rd_data = m_data[ra];
        e_rd_seg  = m_seg[ra];
        e_ld_ok = le && ld_rule(m_seg[la], ls);
        e_ex_ok = ee && !(le && la == ea) && ex_rule(m_seg[ea], es);
        if (e_ld_ok) begin m_data[la] = ld; m_seg[la] = ls; end
        if (e_ex_ok) begin m_data[ea] = ed; m_seg[ea] = es; end
        @(posedge clk);
        #1;
        ld_en = 1'b0; ex_en = 1'b0;
    endtask

    task automatic check_flags(input string req);
        check({req, " ld_ack"}, 32'(ld_ack), 32'(e_ld_ok));
        check({req, " ld_nak"}, 32'(ld_nak), 32'(ld_en_past && !e_ld_ok));
        check({req, " ex_ack"}, 32'(ex_ack), 32'(e_ex_ok));
        check({req, " ex_nak"}, 32'(ex_nak), 32'(ex_en_past && !e_ex_ok));
    endtask

    task automatic check_read(input string req);
        check({req, " rd_data"}, 32'(rd_data), 32'(e_rd_data));
        check({req, " rd_seg"}, 32'(rd_seg), 32'(e_rd_seg));
    endtask

    logic ld_en_past, ex_en_past;
    always @(posedge clk) begin
        ld_en_past <= ld_en;
        ex_en_past <= ex_en;
        cycles <= cycles + 1;
    end

    initial begin
        wait (cycles >= 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);
        for (int i = 0; i < 256; i++) begin m_data[i] = '0; m_seg[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        // R1: flags low while and right after reset
        check("R1 ld_ack", 32'(ld_ack), 0);
        check("R1 ex_nak", 32'(ex_nak), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every word starts free and zero
        for (int a = 0; a < 256; a++) begin
            step(0, 0, 0, 0, 0, 0, 0, 0, 8'(a));
            check_read("R1");
        end

        // R3 R4 R10: loader claims word 20 as handler code (tag 3)
        step(1, 20, 16'hBEEF, 3'd3, 0, 0, 0, 0, 20);
        check_flags("R4");
        check_read("R2");   // R2: old contents at the same edge
        step(0, 0, 0, 0, 0, 0, 0, 0, 20);
        check("R10 data", 32'(rd_data), 32'hBEEF);
        check("R3 tag", 32'(rd_seg), 32'd3);

        // R4 R7: loader tries a foreign class (tag 5) on word 20
        step(1, 20, 16'h1111, 3'd5, 0, 0, 0, 0, 20);
        check("R4 ld_nak", 32'(ld_nak), 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 20);
        check("R7 data", 32'(rd_data), 32'hBEEF);
        check("R7 tag", 32'(rd_seg), 32'd3);

        // R4: same-class rewrite accepted
        step(1, 20, 16'h2222, 3'd3, 0, 0, 0, 0, 20);
        check("R4 ld_ack", 32'(ld_ack), 1);

        // R6 R7: execution port writes dynamic data over handler code
        step(0, 0, 0, 0, 1, 20, 16'h3333, 3'd6, 20);
        check("R6 ex_nak", 32'(ex_nak), 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 20);
        check("R7 data", 32'(rd_data), 32'h2222);

        // R6: execution port with privileged tag on a free word
        step(0, 0, 0, 0, 1, 40, 16'h4444, 3'd4, 40);
        check("R6 priv tag", 32'(ex_nak), 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 40);
        check("R7 tag", 32'(rd_seg), 32'd0);

        // R6 R10: execution port dynamic write to a free word
        step(0, 0, 0, 0, 1, 41, 16'h5555, 3'd6, 41);
        check("R6 ex_ack", 32'(ex_ack), 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 41);
        check("R10 data", 32'(rd_data), 32'h5555);
        check("R10 tag", 32'(rd_seg), 32'd6);

        // R5: tags 7 and 0 refused on the loader port
        step(1, 50, 16'h6666, 3'd7, 0, 0, 0, 0, 50);
        check("R5 tag7", 32'(ld_nak), 1);
        step(1, 50, 16'h6666, 3'd0, 0, 0, 0, 0, 50);
        check("R5 tag0", 32'(ld_nak), 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 50);
        check("R5 untouched", 32'(rd_data), 0);

        // R9: collision on word 60, loader wins
        step(1, 60, 16'h7777, 3'd6, 1, 60, 16'h8888, 3'd6, 60);
        check("R9 ld_ack", 32'(ld_ack), 1);
        check("R9 ex_nak", 32'(ex_nak), 1);
        check("R9 ex_ack", 32'(ex_ack), 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 60);
        check("R9 data", 32'(rd_data), 32'h7777);

        // R8: idle cycle leaves results low
        check("R8 idle", 32'({ld_ack, ld_nak, ex_ack, ex_nak}), 0);

        // Random traffic in a narrow window
        for (int n = 0; n < 4000; n++) begin
            logic       le, ee;
            logic [7:0] la, ea, ra;
            le = 1'($urandom);
            ee = 1'($urandom);
            la = 8'($urandom_range(0, 15));
            ea = 8'($urandom_range(0, 15));
            ra = 8'($urandom_range(0, 15));
            step(le, la, 16'($urandom), 3'($urandom), ee, ea, 16'($urandom),
                 ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd6, ra);
            check_flags("R8");
            check_read("R2");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule